// File: doc/BRIEF.md
# Peak-tracking bang-bang phase detector for 4-PAM

This block is a baud-rate bang-bang phase detector for a 4-PAM receiver. It moves the sampling phase toward the widest vertical eye opening, not toward the zero crossings. Each symbol period it takes one sliced data sample. That sample comes as a three-bit thermometer code from the level comparators, the sign of the signal slope at the sampling instant, and an optional error-sign bit measured against the monitored level. It issues an early or late pulse only when the sample sits at a monitored outer level.

The direction follows a sign-sign rule. The next phase equals the present phase minus a fixed step times the error sign times the slope sign. When the error comparator is not used, the error sign is assumed: at the top level a sample cannot lie above it, so the error is never positive; at the bottom level the error is never negative. A saturating signed accumulator integrates the pulses for a digital loop filter or for test observation.

Top module: `peak_phase_det`

## Requirements
- R1: `lvl_thermo` is a thermometer code: 3'b111 means the +1.5 level and 3'b000 means the -1.5 level. Every other code gives no pulse. This covers the inner levels 3'b011 and 3'b001 and bubble codes such as 3'b010 and 3'b101.
- R2: `lvl_sel[0]` enables monitoring of +1.5 and `lvl_sel[1]` enables monitoring of -1.5. Both may be set together. With 2'b00 no pulse is ever produced.
- R3: When `use_err_bit`=0 and +1.5 is monitored and received, `slope_pos`=1 gives late and `slope_pos`=0 gives early. `err_pos` has no effect.
- R4: When `use_err_bit`=0 and -1.5 is monitored and received, `slope_pos`=1 gives early and `slope_pos`=0 gives late. `err_pos` has no effect.
- R5: When `use_err_bit`=1 and a monitored level is received, the detector asserts late if `err_pos` differs from `slope_pos` and early if they are equal (`err_pos`=1 means the sample lies above the monitored level).
- R6: Early and late are registered and appear on the clock edge after the sample. They are never both high. A cycle with `smp_vld`=0 gives neither.
- R7: `step` is 2'b01 (+1) with late, 2'b11 (-1) with early, and 2'b00 otherwise.
- R8: `phase_acc` changes on the same edge as the pulses: +1 for late and -1 for early. On every edge the result is clamped to the range from -`sat_lim` to +`sat_lim`, using the `sat_lim` present at that edge.
- R9: While `rst_n` is low, early, late, `step` and `phase_acc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A data sample is present this cycle |
| slope_pos | input | 1 | Sign of the slope at the sampling instant, 1 = rising |
| lvl_thermo | input | 3 | Thermometer code from the level comparators |
| err_pos | input | 1 | Error sign against the monitored level, 1 = above |
| lvl_sel | input | 2 | Bit 0 monitors +1.5, bit 1 monitors -1.5 |
| use_err_bit | input | 1 | 1 = use `err_pos`, 0 = assume the error sign |
| sat_lim | input | ACC_W-1 | Accumulator magnitude limit |
| early | output | 1 | Retard the sampling phase |
| late | output | 1 | Advance the sampling phase |
| step | output | 2 | Signed phase step: +1, -1 or 0 |
| phase_acc | output | ACC_W | Signed saturating pulse accumulator |

## Verification
Every result of the block is due exactly one rising edge after the sample that causes it. That includes the pulses, the step code and the new accumulator value. The accumulator clamp also uses the limit present at that same edge.

The driver applies a sample on the falling edge and pushes one expected entry for every cycle, idle cycles included. The monitor pops one entry 1 ns after each rising edge. Each entry therefore meets the outputs of the edge that registered its sample and never those of a neighbour.

// File: rtl/peak_phase_det.sv
module peak_phase_det #(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic                    slope_pos,
  input  logic [2:0]              lvl_thermo,
  input  logic                    err_pos,
  input  logic [1:0]              lvl_sel,
  input  logic                    use_err_bit,
  input  logic [ACC_W-2:0]        sat_lim,
  output logic                    early,
  output logic                    late,
  output logic [1:0]              step,
  output logic signed [ACC_W-1:0] phase_acc
);

  localparam int SUM_W = ACC_W + 1;

  logic hit_top, hit_bot, hit, err_eff, late_d, early_d;
  logic signed [SUM_W-1:0] lim_s, acc_ext, delta, sum, clamped;

  assign hit_top = smp_vld & lvl_sel[0] & (lvl_thermo == 3'b111);
  assign hit_bot = smp_vld & lvl_sel[1] & (lvl_thermo == 3'b000);
  assign hit     = hit_top | hit_bot;

  // assumed error sign: non-positive at the top, non-negative at the bottom
  assign err_eff = use_err_bit ? err_pos : hit_bot;

  assign late_d  = hit & (err_eff ^ slope_pos);
  assign early_d = hit & ~(err_eff ^ slope_pos);

  assign lim_s   = $signed({2'b00, sat_lim});
  assign acc_ext = {phase_acc[ACC_W-1], phase_acc};

  always_comb begin
    delta = '0;
    if (late_d)       delta = SUM_W'(1);
    else if (early_d) delta = '1;
  end

  assign sum = acc_ext + delta;

  always_comb begin
    clamped = sum;
    if (sum > lim_s)       clamped = lim_s;
    else if (sum < -lim_s) clamped = -lim_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early     <= 1'b0;
      late      <= 1'b0;
      phase_acc <= '0;
    end else begin
      early     <= early_d;
      late      <= late_d;
      phase_acc <= clamped[ACC_W-1:0];
    end
  end

  assign step = {early, early | late};

endmodule

module peak_phase_det_chk #(
  parameter int ACC_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic                    slope_pos,
  input logic [2:0]              lvl_thermo,
  input logic                    err_pos,
  input logic [1:0]              lvl_sel,
  input logic                    use_err_bit,
  input logic [ACC_W-2:0]        sat_lim,
  input logic                    early,
  input logic                    late,
  input logic [1:0]              step,
  input logic signed [ACC_W-1:0] phase_acc
);

  logic signed [ACC_W:0] lim_c, acc_c;
  assign lim_c = $signed({2'b00, sat_lim});
  assign acc_c = {phase_acc[ACC_W-1], phase_acc};

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(early && late));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> (!early && !late));

  a_r1_inner_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lvl_thermo) != 3'b111 && $past(lvl_thermo) != 3'b000) |-> (!early && !late));

  a_r3_top_assumed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld && lvl_sel[0] && lvl_thermo == 3'b111 && !use_err_bit)
      |-> (late == $past(slope_pos) && early == !$past(slope_pos)));

  a_r4_bot_assumed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld && lvl_sel[1] && lvl_thermo == 3'b000 && !use_err_bit)
      |-> (early == $past(slope_pos) && late == !$past(slope_pos)));

  a_r5_explicit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld && use_err_bit &&
          ((lvl_sel[0] && lvl_thermo == 3'b111) || (lvl_sel[1] && lvl_thermo == 3'b000)))
      |-> (late == ($past(err_pos) != $past(slope_pos)) && early == ($past(err_pos) == $past(slope_pos))));

  a_r7_step_late: assert property (@(posedge clk) disable iff (!rst_n)
    late |-> step == 2'b01);

  a_r7_step_early: assert property (@(posedge clk) disable iff (!rst_n)
    early |-> step == 2'b11);

  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (acc_c <= $past(lim_c) && acc_c >= -$past(lim_c)));

  a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (late && $stable(sat_lim) && $past(acc_c) < lim_c && $past(acc_c) >= -lim_c)
      |-> acc_c == $past(acc_c) + 1);

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (early && $stable(sat_lim) && $past(acc_c) > -lim_c && $past(acc_c) <= lim_c)
      |-> acc_c == $past(acc_c) - 1);

endmodule

bind peak_phase_det peak_phase_det_chk #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/peak_phase_det_tb.sv
`timescale 1ns/1ps
module peak_phase_det_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0, slope_pos = 1'b0, err_pos = 1'b0, use_err_bit = 1'b0;
  logic [2:0] lvl_thermo = 3'b000;
  logic [1:0] lvl_sel = 2'b00;
  logic [6:0] sat_lim = 7'd20;
  logic early, late;
  logic [1:0] step;
  logic signed [7:0] phase_acc;

  always #2 clk = ~clk;

  peak_phase_det #(.ACC_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .slope_pos(slope_pos),
    .lvl_thermo(lvl_thermo), .err_pos(err_pos), .lvl_sel(lvl_sel),
    .use_err_bit(use_err_bit), .sat_lim(sat_lim),
    .early(early), .late(late), .step(step), .phase_acc(phase_acc)
  );

  typedef struct {
    logic  e;
    logic  l;
    int    acc;
    string req;
  } exp_t;

  exp_t q[$];
  int n_vec = 0, n_bad = 0, m_acc = 0;
  bit finished = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string req, input int act, input int exp_v, input string what);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [2:0] lv, input logic er,
                       input logic [1:0] sel, input logic ue, input int lim, input string req);
    logic top, bot, e, l;
    int nxt;
    exp_t it;
    @(negedge clk);
    smp_vld = v; slope_pos = s; lvl_thermo = lv; err_pos = er;
    lvl_sel = sel; use_err_bit = ue; sat_lim = 7'(lim);
    top = v && sel[0] && lv == 3'b111;
    bot = v && sel[1] && lv == 3'b000;
    e = 1'b0; l = 1'b0;
    if (top || bot) begin
      if (ue) begin
        l = (er != s); e = (er == s);
      end else if (top) begin
        l = s; e = !s;
      end else begin
        e = s; l = !s;
      end
    end
    nxt = m_acc + (l ? 1 : 0) - (e ? 1 : 0);
    if (nxt > lim) nxt = lim;
    if (nxt < -lim) nxt = -lim;
    m_acc = nxt;
    it.e = e; it.l = l; it.acc = nxt; it.req = req;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t it;
      int st;
      it = q.pop_front();
      check(it.req, int'(early), int'(it.e), "early");
      check(it.req, int'(late), int'(it.l), "late");
      st = it.l ? 1 : (it.e ? 3 : 0);
      check("R7", int'(step), st, "step");
      check("R8", int'(phase_acc), it.acc, "phase_acc");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9", int'(early), 0, "early");
    check("R9", int'(late), 0, "late");
    check("R9", int'(step), 0, "step");
    check("R9", int'(phase_acc), 0, "phase_acc");
    rst_n = 1'b1;

    // R3 top level, assumed error, err_pos ignored
    drive(1, 1, 3'b111, 1, 2'b01, 0, 20, "R3");
    drive(1, 0, 3'b111, 0, 2'b01, 0, 20, "R3");
    drive(1, 1, 3'b111, 0, 2'b01, 0, 20, "R3");
    drive(1, 0, 3'b111, 1, 2'b01, 0, 20, "R3");
    // R1 inner levels and bubble codes
    drive(1, 1, 3'b011, 0, 2'b11, 0, 20, "R1");
    drive(1, 0, 3'b001, 1, 2'b11, 1, 20, "R1");
    drive(1, 1, 3'b010, 1, 2'b11, 0, 20, "R1");
    drive(1, 0, 3'b101, 0, 2'b11, 1, 20, "R1");
    // R4 bottom level, assumed error
    drive(1, 1, 3'b000, 0, 2'b10, 0, 20, "R4");
    drive(1, 0, 3'b000, 1, 2'b10, 0, 20, "R4");
    drive(1, 0, 3'b000, 0, 2'b10, 0, 20, "R4");
    // R2 level selection
    drive(1, 1, 3'b000, 0, 2'b01, 0, 20, "R2");
    drive(1, 1, 3'b111, 0, 2'b10, 0, 20, "R2");
    drive(1, 1, 3'b111, 0, 2'b00, 0, 20, "R2");
    drive(1, 1, 3'b000, 0, 2'b00, 1, 20, "R2");
    drive(1, 1, 3'b111, 0, 2'b11, 0, 20, "R2");
    drive(1, 1, 3'b000, 0, 2'b11, 0, 20, "R2");
    // R5 explicit error bit
    for (int k = 0; k < 8; k++)
      drive(1, k[0], k[2] ? 3'b111 : 3'b000, k[1], 2'b11, 1, 20, "R5");
    // R6 no valid sample
    drive(0, 1, 3'b111, 0, 2'b11, 0, 20, "R6");
    drive(0, 0, 3'b000, 0, 2'b11, 1, 20, "R6");
    // R8 saturation
    for (int k = 0; k < 30; k++) drive(1, 1, 3'b111, 0, 2'b01, 0, 3, "R8");
    for (int k = 0; k < 10; k++) drive(1, 0, 3'b111, 0, 2'b01, 0, 3, "R8");
    for (int k = 0; k < 15; k++) drive(1, 1, 3'b111, 0, 2'b01, 0, 10, "R8");
    drive(0, 0, 3'b011, 0, 2'b01, 0, 2, "R8");
    drive(1, 1, 3'b111, 0, 2'b01, 0, 0, "R8");
    drive(1, 0, 3'b111, 0, 2'b01, 0, 0, "R8");
    for (int k = 0; k < 140; k++) drive(1, 0, 3'b000, 0, 2'b10, 0, 127, "R8");
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] | r[1], r[2], r[5:3], r[6], r[8:7], r[9], int'(r[14:10]), "R6");
    end
    drive(0, 0, 3'b011, 0, 2'b00, 0, 20, "R6");
    repeat (3) @(negedge clk);
    report();
  end

endmodule